// File: doc/BRIEF.md
# Nibble-Serial Eight-Bit ALU

This block computes byte-wide arithmetic, logic, shift and rotate results with a single four-bit adder/logic core. The core runs twice for each operation. On the start cycle, the live low halves of the operands pass through the core. That partial result and the carry out of the low half are captured in the same cycle. The upper halves of the prepared operands are captured with them. On the following cycle, the core processes the upper halves using the captured carry. The block then joins both halves into the final byte and registers five flags.

Shifts and rotates act on operand A on its way into the core. Subtraction uses inversion of the B operand path. The carry that passes between the two halves becomes the half-carry flag.

A caller presents the operands, an operation code and a carry input, and pulses `start`. Two cycles later `done` pulses and the result and flags are valid. They stay unchanged until the next operation completes. `wrStrobe` tells a surrounding register file whether the result is to be written back. A compare operation leaves it low.

Top module: `nibble_alu`

## Requirements
- R1: `done` is a one-cycle pulse in the second cycle after the cycle in which `start` is sampled high while idle. A `start` seen in the cycle right after an accepted one is ignored, and the cycle after that may accept again.
- R2: ADD (code 0) gives A+B. ADC (code 1) gives A+B+carryIn. `flagC` is the carry out of bit 7.
- R3: SUB (code 2) gives A-B. SBC (code 3) gives A-B-carryIn. CMP (code 4) computes A-B. For these codes `flagC` is the borrow out of bit 7.
- R4: For arithmetic codes 0 to 4 and 8 to 9, `flagH` is the carry (for codes 0, 1 and 8) or borrow (for codes 2, 3, 4 and 9) between bit 3 and bit 4.
- R5: `flagV` is signed two's-complement overflow for codes 0 to 4 and 8 to 9. It is 0 for every other code.
- R6: AND (5), OR (6) and XOR (7) give the bitwise result with `flagC`=0. `flagH`=1 for AND and 0 for OR and XOR. Codes 14 and 15 pass A unchanged with `flagC`=`flagH`=0.
- R7: INC (8) gives A+1 and DEC (9) gives A-1. B is ignored, and `flagC` equals `carryIn`.
- R8: Code 10 shifts A left and fills bit 0 with 0. Code 11 shifts A right and fills bit 7 with 0. Code 12 rotates left through the carry, putting carryIn into bit 0. Code 13 rotates right through the carry, putting carryIn into bit 7. `flagC` receives the bit shifted out, and `flagH`=0.
- R9: `flagZ` is 1 exactly when the 8-bit result is zero. `flagS` equals result bit 7.
- R10: `wrStrobe` pulses together with `done` for every code except CMP. For CMP it stays low, while `result` still shows A-B.
- R11: After reset, `done`, `wrStrobe`, `result` and all flags are 0.
- R12: `result` and the flags hold their values between completions, even when the operand inputs change during an operation.

Ports listed in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| opCode | input | 4 | Operation code |
| opA | input | 8 | Operand A (sampled with start) |
| opB | input | 8 | Operand B (sampled with start) |
| carryIn | input | 1 | Carry/borrow input (sampled with start) |
| done | output | 1 | Completion pulse |
| wrStrobe | output | 1 | Write-back request, pulses with done |
| result | output | 8 | Result byte |
| flagC | output | 1 | Carry / borrow / shifted-out bit |
| flagH | output | 1 | Carry or borrow between the halves |
| flagV | output | 1 | Signed overflow |
| flagZ | output | 1 | Zero result |
| flagS | output | 1 | Result sign |

## Verification
The hardest case to reach is the upper-half pass running while the port inputs no longer describe the operation in flight. This covers three situations: the operands and code already changed, `start` asserted again during the second cycle, and a new operation issued in the very next idle cycle.

The stimulus scrambles A, B, the code and the carry in the cycle after each accepted start. It also holds `start` high for two cycles on many operations, so the second sample lands on the busy cycle. It packs operations back to back among random ones.

A behavioural model predicts `done` and every output on every clock. Any captured-state or busy-handling fault therefore shows up as a mismatch.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,  OP_AND  = 4'd5,  OP_OR   = 4'd6,  OP_XOR  = 4'd7,
    OP_INC  = 4'd8,  OP_DEC  = 4'd9,  OP_SHL  = 4'd10, OP_SHR  = 4'd11,
    OP_ROL  = 4'd12, OP_ROR  = 4'd13, OP_RSV0 = 4'd14, OP_RSV1 = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {FN_ADD, FN_AND, FN_OR, FN_XOR} coreFn_e;
  typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_EXT, CI_NEXT} cinSel_e;
  typedef enum logic [1:0] {B_PASS, B_ZERO, B_ONE} bSel_e;
  typedef enum logic [2:0] {SH_NONE, SH_LL, SH_LR, SH_RL, SH_RR} shSel_e;
  typedef enum logic [2:0] {C_ADD, C_SUB, C_KEEP, C_ZERO, C_SHIFT} cSel_e;
  typedef enum logic [1:0] {H_CARRY, H_BORROW, H_ONE, H_ZERO} hSel_e;

  typedef struct packed {
    coreFn_e fn;
    logic    invB;
    cinSel_e cin;
    bSel_e   bSel;
    shSel_e  sh;
    cSel_e   cSel;
    hSel_e   hSel;
    logic    vEn;
    logic    wrEn;
  } aluDec_t;

  typedef struct packed {
    logic captureLo;
    logic finishHi;
    logic useLatched;
  } aluStb_t;

  function automatic aluDec_t decodeOp(aluOp_e op);
    aluDec_t d;
    d.fn   = FN_ADD;
    d.invB = 1'b0;
    d.cin  = CI_ZERO;
    d.bSel = B_PASS;
    d.sh   = SH_NONE;
    d.cSel = C_ADD;
    d.hSel = H_CARRY;
    d.vEn  = 1'b1;
    d.wrEn = 1'b1;
    case (op)
      OP_ADD: ;
      OP_ADC: d.cin = CI_EXT;
      OP_SUB, OP_CMP: begin
        d.invB = 1'b1; d.cin = CI_ONE; d.cSel = C_SUB; d.hSel = H_BORROW;
        d.wrEn = (op != OP_CMP);
      end
      OP_SBC: begin
        d.invB = 1'b1; d.cin = CI_NEXT; d.cSel = C_SUB; d.hSel = H_BORROW;
      end
      OP_AND: begin d.fn = FN_AND; d.cSel = C_ZERO; d.hSel = H_ONE;  d.vEn = 1'b0; end
      OP_OR:  begin d.fn = FN_OR;  d.cSel = C_ZERO; d.hSel = H_ZERO; d.vEn = 1'b0; end
      OP_XOR: begin d.fn = FN_XOR; d.cSel = C_ZERO; d.hSel = H_ZERO; d.vEn = 1'b0; end
      OP_INC: begin d.bSel = B_ZERO; d.cin = CI_ONE; d.cSel = C_KEEP; end
      OP_DEC: begin
        d.bSel = B_ONE; d.invB = 1'b1; d.cin = CI_ONE; d.cSel = C_KEEP; d.hSel = H_BORROW;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        d.bSel = B_ZERO; d.cSel = C_SHIFT; d.hSel = H_ZERO; d.vEn = 1'b0;
        case (op)
          OP_SHL:  d.sh = SH_LL;
          OP_SHR:  d.sh = SH_LR;
          OP_ROL:  d.sh = SH_RL;
          default: d.sh = SH_RR;
        endcase
      end
      default: begin
        d.fn = FN_OR; d.bSel = B_ZERO; d.cSel = C_ZERO; d.hSel = H_ZERO; d.vEn = 1'b0;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/nib_alu_core.sv
module nib_alu_core
  import nib_alu_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] x,
  input  logic [NIB_W-1:0] y,
  input  logic             cin,
  input  coreFn_e          fn,
  output logic [NIB_W-1:0] r,
  output logic             cout,
  output logic             cMsb
);
  logic [NIB_W:0]   sumFull;
  logic [NIB_W-1:0] sumLow;

  always_comb begin
    sumFull = (NIB_W+1)'(x) + (NIB_W+1)'(y) + (NIB_W+1)'(cin);
    sumLow  = NIB_W'(x[NIB_W-2:0]) + NIB_W'(y[NIB_W-2:0]) + NIB_W'(cin);
    cout    = sumFull[NIB_W];
    cMsb    = sumLow[NIB_W-1];
    case (fn)
      FN_AND:  r = x & y;
      FN_OR:   r = x | y;
      FN_XOR:  r = x ^ y;
      default: r = sumFull[NIB_W-1:0];
    endcase
  end
endmodule

// File: rtl/nib_alu_ctrl.sv
module nib_alu_ctrl
  import nib_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] opCode,
  output aluStb_t    stb,
  output aluDec_t    dec,
  output logic       done
);
  typedef enum logic {ST_IDLE, ST_HIGH} state_e;
  state_e state;
  aluOp_e opHeld;

  always_comb begin
    stb.captureLo  = (state == ST_IDLE) && start;
    stb.finishHi   = (state == ST_HIGH);
    stb.useLatched = (state == ST_HIGH);
    dec = decodeOp((state == ST_HIGH) ? opHeld : aluOp_e'(opCode));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      opHeld <= OP_ADD;
      done   <= 1'b0;
    end else begin
      done <= stb.finishHi;
      if (stb.captureLo) begin
        state  <= ST_HIGH;
        opHeld <= aluOp_e'(opCode);
      end else begin
        state  <= ST_IDLE;
      end
    end
  end

  a_r1_done_follows_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH) |=> done);
  a_r1_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && start) |=> (state == ST_IDLE));
  a_r1_start_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    stb.captureLo |=> (!done && stb.finishHi));
endmodule

// File: rtl/nib_alu_dp.sv
module nib_alu_dp
  import nib_alu_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  aluStb_t               stb,
  input  aluDec_t               dec,
  input  logic [2*NIB_W-1:0]    opA,
  input  logic [2*NIB_W-1:0]    opB,
  input  logic                  carryIn,
  output logic [2*NIB_W-1:0]    result,
  output logic                  wrStrobe,
  output logic                  flagC,
  output logic                  flagH,
  output logic                  flagV,
  output logic                  flagZ,
  output logic                  flagS
);
  localparam int DW = 2 * NIB_W;

  logic [DW-1:0]    shA, bVal, bEff;
  logic             shOut, cinLo;
  logic [NIB_W-1:0] coreX, coreY, coreR;
  logic             coreCin, coreCout, coreCMsb;

  logic [NIB_W-1:0] hiA, hiB, loRes;
  logic             midCarry, shOutHeld, cinHeld;

  always_comb begin
    case (dec.sh)
      SH_LL:   begin shA = {opA[DW-2:0], 1'b0};    shOut = opA[DW-1]; end
      SH_LR:   begin shA = {1'b0, opA[DW-1:1]};    shOut = opA[0];    end
      SH_RL:   begin shA = {opA[DW-2:0], carryIn}; shOut = opA[DW-1]; end
      SH_RR:   begin shA = {carryIn, opA[DW-1:1]}; shOut = opA[0];    end
      default: begin shA = opA;                    shOut = 1'b0;      end
    endcase
    case (dec.bSel)
      B_ZERO:  bVal = '0;
      B_ONE:   bVal = DW'(1);
      default: bVal = opB;
    endcase
    bEff = dec.invB ? ~bVal : bVal;
    case (dec.cin)
      CI_ONE:  cinLo = 1'b1;
      CI_EXT:  cinLo = carryIn;
      CI_NEXT: cinLo = ~carryIn;
      default: cinLo = 1'b0;
    endcase
    coreX   = stb.useLatched ? hiA      : shA[NIB_W-1:0];
    coreY   = stb.useLatched ? hiB      : bEff[NIB_W-1:0];
    coreCin = stb.useLatched ? midCarry : cinLo;
  end

  nib_alu_core #(.NIB_W(NIB_W)) u_core (
    .x(coreX), .y(coreY), .cin(coreCin), .fn(dec.fn),
    .r(coreR), .cout(coreCout), .cMsb(coreCMsb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiA <= '0; hiB <= '0; loRes <= '0;
      midCarry <= 1'b0; shOutHeld <= 1'b0; cinHeld <= 1'b0;
    end else if (stb.captureLo) begin
      hiA       <= shA[DW-1:NIB_W];
      hiB       <= bEff[DW-1:NIB_W];
      loRes     <= coreR;
      midCarry  <= coreCout;
      shOutHeld <= shOut;
      cinHeld   <= carryIn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0; wrStrobe <= 1'b0;
      flagC <= 1'b0; flagH <= 1'b0; flagV <= 1'b0; flagZ <= 1'b0; flagS <= 1'b0;
    end else begin
      wrStrobe <= stb.finishHi && dec.wrEn;
      if (stb.finishHi) begin
        result <= {coreR, loRes};
        flagZ  <= ({coreR, loRes} == '0);
        flagS  <= coreR[NIB_W-1];
        flagV  <= dec.vEn && (coreCMsb ^ coreCout);
        case (dec.cSel)
          C_ADD:   flagC <= coreCout;
          C_SUB:   flagC <= ~coreCout;
          C_KEEP:  flagC <= cinHeld;
          C_SHIFT: flagC <= shOutHeld;
          default: flagC <= 1'b0;
        endcase
        case (dec.hSel)
          H_CARRY:  flagH <= midCarry;
          H_BORROW: flagH <= ~midCarry;
          H_ONE:    flagH <= 1'b1;
          default:  flagH <= 1'b0;
        endcase
      end
    end
  end

  a_r6_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.finishHi && dec.cSel == C_ZERO) |=> !flagC);
  a_r5_no_overflow_off: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.finishHi && !dec.vEn) |=> !flagV);
  a_r10_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.finishHi && !dec.wrEn) |=> !wrStrobe);
  a_r12_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.finishHi |=> ($stable(result) && $stable(flagZ) && !wrStrobe));
  a_r9_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    stb.finishHi |=> (flagZ == (result == '0)) && (flagS == result[DW-1]));
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import nib_alu_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [3:0]         opCode,
  input  logic [2*NIB_W-1:0] opA,
  input  logic [2*NIB_W-1:0] opB,
  input  logic               carryIn,
  output logic               done,
  output logic               wrStrobe,
  output logic [2*NIB_W-1:0] result,
  output logic               flagC,
  output logic               flagH,
  output logic               flagV,
  output logic               flagZ,
  output logic               flagS
);
  aluStb_t stb;
  aluDec_t dec;

  nib_alu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .opCode(opCode),
    .stb(stb), .dec(dec), .done(done)
  );

  nib_alu_dp #(.NIB_W(NIB_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .dec(dec),
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .result(result), .wrStrobe(wrStrobe),
    .flagC(flagC), .flagH(flagH), .flagV(flagV), .flagZ(flagZ), .flagS(flagS)
  );
endmodule

// File: tb/nibble_alu_tb.sv
module nibble_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] opA = 8'd0, opB = 8'd0;
  logic       carryIn = 1'b0;
  logic       done, wrStrobe, flagC, flagH, flagV, flagZ, flagS;
  logic [7:0] result;

  int errors = 0;
  int checks = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nibble_alu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opCode(opCode),
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .done(done), .wrStrobe(wrStrobe), .result(result),
    .flagC(flagC), .flagH(flagH), .flagV(flagV), .flagZ(flagZ), .flagS(flagS)
  );

  typedef struct packed {
    logic [7:0] r;
    logic c, h, v, we;
  } exp_t;

  function automatic exp_t refModel(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic ci);
    exp_t e;
    int t, k;
    e = '0;
    e.we = 1'b1;
    case (op)
      4'd0, 4'd1: begin
        k = (op == 4'd1) ? int'(ci) : 0;
        t = int'(a) + int'(b) + k;
        e.r = t[7:0]; e.c = (t > 255);
        e.h = ((int'(a) % 16) + (int'(b) % 16) + k) > 15;
        e.v = (a[7] == b[7]) && (e.r[7] != a[7]);
      end
      4'd2, 4'd3, 4'd4: begin
        k = (op == 4'd3) ? int'(ci) : 0;
        t = int'(a) - int'(b) - k;
        e.r = t[7:0]; e.c = int'(a) < int'(b) + k;
        e.h = (int'(a) % 16) < (int'(b) % 16) + k;
        e.v = (a[7] != b[7]) && (e.r[7] != a[7]);
        e.we = (op != 4'd4);
      end
      4'd5: begin e.r = a & b; e.h = 1'b1; end
      4'd6: e.r = a | b;
      4'd7: e.r = a ^ b;
      4'd8: begin e.r = a + 8'd1; e.c = ci; e.h = (a[3:0] == 4'hF); e.v = (a == 8'h7F); end
      4'd9: begin e.r = a - 8'd1; e.c = ci; e.h = (a[3:0] == 4'h0); e.v = (a == 8'h80); end
      4'd10: begin e.r = {a[6:0], 1'b0}; e.c = a[7]; end
      4'd11: begin e.r = {1'b0, a[7:1]}; e.c = a[0]; end
      4'd12: begin e.r = {a[6:0], ci};   e.c = a[7]; end
      4'd13: begin e.r = {ci, a[7:1]};   e.c = a[0]; end
      default: e.r = a;
    endcase
    return e;
  endfunction

  function automatic string opTag(logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15: return "R6";
      4'd8, 4'd9: return "R7";
      default: return "R8";
    endcase
  endfunction

  // behavioural cycle model
  bit         pend, expDone, expWe, haveOut;
  exp_t       pendVal, outVal;
  logic [3:0] pendOp, lastOp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 0; expDone <= 0; expWe <= 0; haveOut <= 0;
      outVal <= '0; pendVal <= '0; pendOp <= '0; lastOp <= '0;
    end else begin
      expDone <= 0;
      expWe   <= 0;
      if (pend) begin
        pend <= 0; expDone <= 1; expWe <= pendVal.we;
        outVal <= pendVal; lastOp <= pendOp; haveOut <= 1;
      end else if (start) begin
        pend <= 1;
        pendVal <= refModel(opCode, opA, opB, carryIn);
        pendOp <= opCode;
      end
    end
  end

  task automatic check(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (time %0t)", tag, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && !finished) begin
      string t, th;
      t  = !haveOut ? "R11" : (!expDone ? "R12" : opTag(lastOp));
      th = (haveOut && expDone && (lastOp <= 4'd4 || lastOp == 4'd8 || lastOp == 4'd9)) ? "R4" : t;
      check("R1", "done", int'(done), int'(expDone));
      check(t, "result", int'(result), int'(outVal.r));
      check(t, "flagC", int'(flagC), int'(outVal.c));
      check(th, "flagH", int'(flagH), int'(outVal.h));
      check(haveOut ? "R5" : t, "flagV", int'(flagV), int'(outVal.v));
      check(haveOut ? "R9" : t, "flagZ", int'(flagZ), int'(haveOut ? (outVal.r == 8'd0) : 0));
      check(haveOut ? "R9" : t, "flagS", int'(flagS), int'(haveOut ? outVal.r[7] : 0));
      check(haveOut ? "R10" : t, "wrStrobe", int'(wrStrobe), int'(expWe));
    end
  end

  // issue one operation; start stays high for 'hold' cycles, then inputs are scrambled
  task automatic issue(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic ci, int hold);
    opCode = op; opA = a; opB = b; carryIn = ci; start = 1'b1;
    repeat (hold) @(negedge clk);
    start = 1'b0;
    opCode = 4'($urandom); opA = 8'($urandom); opB = 8'($urandom); carryIn = 1'($urandom);
  endtask

  task automatic runOp(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic ci);
    issue(op, a, b, ci, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    repeat (2) @(negedge clk);            // R11 reset state observed
    runOp(4'd0, 8'h0F, 8'h01, 1'b0);      // R4 half carry
    runOp(4'd0, 8'h7F, 8'h01, 1'b0);      // R5 overflow
    runOp(4'd0, 8'hFF, 8'h01, 1'b0);      // R2 carry, R9 zero
    runOp(4'd1, 8'hFF, 8'h00, 1'b1);      // R2 adc
    runOp(4'd2, 8'h10, 8'h01, 1'b0);      // R4 borrow
    runOp(4'd2, 8'h80, 8'h01, 1'b0);      // R5
    runOp(4'd2, 8'h00, 8'h01, 1'b1);      // R3 borrow out
    runOp(4'd3, 8'h05, 8'h05, 1'b1);      // R3 sbc
    runOp(4'd4, 8'h42, 8'h42, 1'b0);      // R10 compare equal
    runOp(4'd4, 8'h10, 8'h20, 1'b0);      // R10 compare less
    runOp(4'd5, 8'hF3, 8'h0F, 1'b1);      // R6 and
    runOp(4'd6, 8'h00, 8'h00, 1'b1);      // R6 or zero
    runOp(4'd7, 8'hA5, 8'hA5, 1'b0);      // R6 xor
    runOp(4'd8, 8'h7F, 8'h33, 1'b0);      // R7 inc
    runOp(4'd8, 8'hFF, 8'h00, 1'b1);      // R7 inc wrap keeps carry
    runOp(4'd9, 8'h80, 8'h55, 1'b1);      // R7 dec
    runOp(4'd9, 8'h00, 8'hFF, 1'b0);      // R7 dec wrap
    runOp(4'd10, 8'h81, 8'h00, 1'b1);     // R8
    runOp(4'd11, 8'h81, 8'h00, 1'b1);     // R8
    runOp(4'd12, 8'h81, 8'h00, 1'b1);     // R8
    runOp(4'd13, 8'h02, 8'h00, 1'b1);     // R8
    runOp(4'd14, 8'h9C, 8'hFF, 1'b1);     // R6 reserved
    runOp(4'd15, 8'h00, 8'hFF, 1'b1);     // R6 reserved
    issue(4'd0, 8'h12, 8'h34, 1'b0, 2);   // R1 start held into busy cycle
    issue(4'd2, 8'h50, 8'h60, 1'b0, 1);   // R1 accepted right after
    repeat (3) @(negedge clk);            // R12 hold
    for (int i = 0; i < 400; i++) begin
      issue(4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1 + int'($urandom % 2));
      repeat (int'($urandom % 3)) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    finishRun();
  end
endmodule